// File: doc/BRIEF.md
# Card Bus Clock Generator with Idle Gating

This block produces the clock for a removable-card bus from the host clock. In divide mode it makes a 50% duty-cycle clock whose period is set by a programmable ratio. In bypass mode it passes the host clock through, gated by an enable flop that switches while the host clock is low. Alongside the clock it gives a one-host-cycle strobe that marks each card clock rising edge, for the shift logic that moves command and data bits.

The clock runs only while software enables it and the supply is fully on. It is held low in reset, while the supply is off, and while the supply is still ramping. With power saving on, the block counts card clock rising edges while both the command path and the data path report idle. After a fixed number of such edges it stops the clock. As soon as either path shows activity, the clock starts again. In divide mode the first rising edge then comes on the next host edge.

The design never cuts a high phase short. A request to stop, or a switch between divide and bypass, lets the current high phase run its full length. A new divide ratio is picked up only when the clock falls.

Top module: `card_clk_gen`

## Requirements
- R1: After reset `card_clk` and `card_rise` are 0. While `clk_en` is 0 the clock produces no rising edge.
- R2: In divide mode a ratio N gives a `card_clk` period of 2*(N+1) host cycles. The clock is high for N+1 cycles and low for N+1 cycles.
- R3: In bypass mode, while running, `card_clk` follows the host clock: it is high in the first half of each host cycle and low in the second half. `card_rise` is 1 in every host cycle.
- R4: The clock runs only when `pwr_state` is 2'b11 (on). The codes 2'b00 (off), 2'b10 (ramping) and 2'b01 (reserved) hold it low with no rising edge, in both modes.
- R5: When running is withdrawn during a high phase, that high phase still lasts its full N+1 host cycles before the output stays low.
- R6: A new `div_ratio` is sampled only when `card_clk` falls, or while the clock is stopped. A high phase in progress keeps the length it started with.
- R7: With `psave_en` = 1 and both `cmd_idle` and `dat_idle` high, the clock stops after exactly 8 card clock rising edges (IDLE_CYC).
- R8: When either idle input drops, the idle count clears. In divide mode `card_clk` goes high on the first host edge after the drop.
- R9: `card_rise` is high for exactly the host cycles that follow a card clock rising edge. In divide mode it never lasts two consecutive cycles.
- R10: A change of `bypass` takes effect only once the divided clock is low and the bypass enable is off. The high phase in progress completes first.
- R11: With `psave_en` = 0, idle inputs never stop the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W | Divide ratio N; the period is 2*(N+1) host cycles |
| bypass | input | 1 | 1 selects bypass of the host clock, 0 selects divide mode |
| clk_en | input | 1 | Clock enable from software |
| psave_en | input | 1 | Power-saving gating enable |
| pwr_state | input | 2 | Supply state: 2'b11 on, 2'b10 ramping, 2'b00 off, 2'b01 reserved |
| cmd_idle | input | 1 | Command path is idle |
| dat_idle | input | 1 | Data path is idle |
| card_clk | output | 1 | Gated card bus clock |
| card_rise | output | 1 | One host cycle per card clock rising edge |

## Verification
The bench builds the block with DIV_W = 4 and IDLE_CYC = 8. A 4-bit ratio makes the widest setting of 15, a 32-cycle period, reachable. The bench moves the ratio between 0, 1, 2 and 5, so it sees both the shortest period of two cycles and high phases long enough to re-time mid-phase. Keeping the idle limit at its real value of eight lets the exact number of rising edges before power-save gating be counted at the ports. The bench also exercises live switches between divide and bypass, and every supply code in both modes.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'b00,
    PWR_RSVD = 2'b01,
    PWR_RAMP = 2'b10,
    PWR_ON   = 2'b11
  } pwr_e;

  // Only a fully powered supply lets the card clock run.
  function automatic logic pwr_allows(input logic [1:0] state);
    return state == PWR_ON;
  endfunction

  // Card clock period, in host cycles, for divide ratio n.
  function automatic int unsigned card_period(input int unsigned n);
    return 2 * (n + 1);
  endfunction

endpackage

// File: rtl/ccg_divider.sv
`timescale 1ns/1ps
module ccg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             phase,
  output logic             rise_tick,
  output logic [DIV_W-1:0] n_act
);

  logic [DIV_W-1:0] cnt;

  // The clock rises on the next edge when it is low, allowed and the count is spent.
  assign rise_tick = !phase && run_ok && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      cnt   <= '0;
      n_act <= '0;
    end else if (!phase) begin
      if (!run_ok) begin
        cnt   <= '0;
        n_act <= div_ratio;
      end else if (cnt == '0) begin
        phase <= 1'b1;
        cnt   <= n_act;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        phase <= 1'b0;
        cnt   <= div_ratio;
        n_act <= div_ratio;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ccg_bypass.sv
`timescale 1ns/1ps
module ccg_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic run_ok,
  output logic run_q,
  output logic en_neg,
  output logic clk_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_ok;
  end

  // The enable changes only while the host clock is low, so the output has no runt pulse.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_neg <= 1'b0;
    else        en_neg <= run_q;
  end

  assign clk_out = clk & en_neg;

endmodule

// File: rtl/ccg_idle.sv
`timescale 1ns/1ps
module ccg_idle #(
  parameter int IDLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic both_idle,
  input  logic edge_seen,
  output logic sleep_q
);

  localparam int CW = $clog2(IDLE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sleep_q <= 1'b0;
    end else if (!both_idle) begin
      cnt     <= '0;
      sleep_q <= 1'b0;
    end else if (!sleep_q && edge_seen) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(IDLE_CYC - 1)) sleep_q <= 1'b1;
    end
  end

endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen #(
  parameter int DIV_W    = 8,
  parameter int IDLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             bypass,
  input  logic             clk_en,
  input  logic             psave_en,
  input  logic [1:0]       pwr_state,
  input  logic             cmd_idle,
  input  logic             dat_idle,
  output logic             card_clk,
  output logic             card_rise
);

  import ccg_pkg::*;

  logic             both_idle;
  logic             sleep_q;
  logic             run_req;
  logic             mode_q;
  logic             quiet;
  logic             div_ok;
  logic             byp_ok;
  logic             div_phase;
  logic             div_tick;
  logic [DIV_W-1:0] n_act;
  logic             byp_run;
  logic             en_neg;
  logic             byp_clk;
  logic             rise_q;

  assign both_idle = cmd_idle & dat_idle;

  // Activity on either path lifts power-save gating at once.
  assign run_req = clk_en & pwr_allows(pwr_state) & ~(psave_en & sleep_q & both_idle);

  // The mode may change only when neither clock source is driving.
  assign quiet  = ~div_phase & ~byp_run & ~en_neg;
  assign div_ok = run_req & ~mode_q & ~bypass;
  assign byp_ok = run_req &  mode_q &  bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= 1'b0;
    else if (quiet) mode_q <= bypass;
  end

  ccg_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_ok    (div_ok),
    .div_ratio (div_ratio),
    .phase     (div_phase),
    .rise_tick (div_tick),
    .n_act     (n_act)
  );

  ccg_bypass u_byp (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_ok  (byp_ok),
    .run_q   (byp_run),
    .en_neg  (en_neg),
    .clk_out (byp_clk)
  );

  ccg_idle #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .both_idle (both_idle),
    .edge_seen (rise_q),
    .sleep_q   (sleep_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= mode_q ? en_neg : div_tick;
  end

  assign card_rise = rise_q;
  assign card_clk  = mode_q ? byp_clk : div_phase;

endmodule

// File: rtl/ccg_checker.sv
`timescale 1ns/1ps
module ccg_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic [1:0]       pwr_state,
  input logic             cmd_idle,
  input logic             dat_idle,
  input logic             card_rise,
  input logic             div_phase,
  input logic [DIV_W-1:0] n_act,
  input logic             mode_q,
  input logic             byp_run,
  input logic             en_neg,
  input logic             sleep_q
);

  logic [DIV_W:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (div_phase) hi_len <= hi_len + 1'b1;
    else                hi_len <= '0;
  end

  AST_HIGH_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_phase) |-> (hi_len == ({1'b0, $past(n_act)} + 1'b1))); // R5

  AST_DISABLED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !div_phase && !mode_q) |=> !div_phase); // R1

  AST_POWER_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state != 2'b11) && !div_phase && !mode_q) |=> !div_phase); // R4

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rise && !mode_q) |=> !card_rise); // R9

  AST_MODE_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(!div_phase && !byp_run && !en_neg)); // R10

  AST_ACTIVITY_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_idle || !dat_idle) |=> !sleep_q); // R8

  AST_BYPASS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && en_neg) |=> card_rise); // R3

endmodule

bind card_clk_gen ccg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .pwr_state (pwr_state),
  .cmd_idle  (cmd_idle),
  .dat_idle  (dat_idle),
  .card_rise (card_rise),
  .div_phase (div_phase),
  .n_act     (n_act),
  .mode_q    (mode_q),
  .byp_run   (byp_run),
  .en_neg    (en_neg),
  .sleep_q   (sleep_q)
);

// File: tb/tb_card_clk_gen.sv
`timescale 1ns/1ps
module tb_card_clk_gen;
  import ccg_pkg::*;

  localparam int DW = 4;
  localparam int IC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] div_ratio = 4'd2;
  logic          bypass = 1'b0, clk_en = 1'b0, psave_en = 1'b0;
  logic [1:0]    pwr_state = 2'b11;
  logic          cmd_idle = 1'b0, dat_idle = 1'b0;
  logic          card_clk, card_rise;

  int total = 0, bad = 0;
  int rise_cnt = 0, hi_run = 0, last_hi = 0;
  bit done = 0;

  // Reference model state
  int m_ph = 0, m_rem = 0, m_nact = 0, m_mode = 0, m_brun = 0, m_en = 0;
  int m_icnt = 0, m_slp = 0, m_rise = 0;

  always #5 clk = ~clk;

  card_clk_gen #(.DIV_W(DW), .IDLE_CYC(IC)) dut (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .bypass(bypass),
    .clk_en(clk_en), .psave_en(psave_en), .pwr_state(pwr_state),
    .cmd_idle(cmd_idle), .dat_idle(dat_idle),
    .card_clk(card_clk), .card_rise(card_rise));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model: level plus cycles left in that level; a mode change waits for silence.
  always @(posedge clk) begin
    int both, on, dok, bok, silent;
    int n_ph, n_rem, n_nact, n_mode, n_rise, n_icnt, n_slp;
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_nact = 0; m_mode = 0; m_brun = 0;
      m_icnt = 0; m_slp = 0; m_rise = 0;
    end else begin
      both   = (cmd_idle && dat_idle) ? 1 : 0;
      on     = (clk_en && pwr_state == 2'b11 && !(psave_en && m_slp && both)) ? 1 : 0;
      silent = (m_ph == 0 && m_brun == 0 && m_en == 0) ? 1 : 0;
      dok    = (on && m_mode == 0 && !bypass) ? 1 : 0;
      bok    = (on && m_mode == 1 && bypass) ? 1 : 0;
      n_ph = m_ph; n_rem = m_rem; n_nact = m_nact;
      n_rise = (m_mode == 1) ? m_en : ((m_ph == 0 && dok && m_rem == 0) ? 1 : 0);
      if (m_ph == 1) begin
        if (m_rem == 0) begin n_ph = 0; n_rem = int'(div_ratio); n_nact = int'(div_ratio); end
        else n_rem = m_rem - 1;
      end else if (!dok) begin
        n_rem = 0; n_nact = int'(div_ratio);
      end else if (m_rem == 0) begin
        n_ph = 1; n_rem = m_nact;
      end else n_rem = m_rem - 1;
      n_mode = silent ? int'(bypass) : m_mode;
      n_icnt = m_icnt; n_slp = m_slp;
      if (!both) begin n_icnt = 0; n_slp = 0; end
      else if (!m_slp && m_rise) begin
        n_icnt = m_icnt + 1;
        if (n_icnt == IC) n_slp = 1;
      end
      m_ph = n_ph; m_rem = n_rem; m_nact = n_nact; m_mode = n_mode;
      m_brun = bok; m_rise = n_rise; m_icnt = n_icnt; m_slp = n_slp;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) m_en = 0;
    else        m_en = m_brun;
  end

  // Compare on every clock, while the host clock is high.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(m_mode == 1 ? "R3 card_clk vs model" : "R2 card_clk vs model",
            int'(card_clk), m_mode == 1 ? m_en : m_ph);
      check("R9 card_rise vs model", int'(card_rise), m_rise);
      if (card_rise) rise_cnt++;
      if (card_clk) hi_run++;
      else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise();
    @(posedge clk); #2;
    while (card_rise !== 1'b1) begin @(posedge clk); #2; end
  endtask

  task automatic wait_low();
    @(posedge clk); #2;
    while (card_clk !== 1'b0) begin @(posedge clk); #2; end
  endtask

  initial begin
    cyc(3);
    @(posedge clk); #2;
    check("R1 reset card_clk", int'(card_clk), 0);
    check("R1 reset card_rise", int'(card_rise), 0);
    @(negedge clk); rst_n = 1'b1;
    rise_cnt = 0; cyc(10);
    check("R1 no edge while disabled", rise_cnt, 0);

    // R2: ratio 2, period 6
    @(negedge clk); clk_en = 1'b1;
    cyc(6); rise_cnt = 0; cyc(60);
    check("R2 edges in 60 cycles, N=2", rise_cnt, 60 / int'(card_period(2)));
    check("R2 high length N=2", last_hi, 3);

    // R6: change ratio while high
    wait_rise();
    @(negedge clk); div_ratio = 4'd5;
    wait_low();
    check("R6 running high phase keeps old length", last_hi, 3);
    cyc(30);
    check("R6 new ratio high length", last_hi, 6);

    // R5: withdraw enable during high phase
    wait_rise();
    @(negedge clk); clk_en = 1'b0;
    wait_low();
    check("R5 high phase completes", last_hi, 6);
    cyc(2); rise_cnt = 0; cyc(20);
    check("R1 disabled stays quiet", rise_cnt, 0);

    // R4: supply states
    @(negedge clk); clk_en = 1'b1; div_ratio = 4'd1;
    for (int s = 0; s < 3; s++) begin
      cyc(10);
      @(negedge clk); pwr_state = (s == 0) ? 2'b10 : ((s == 1) ? 2'b00 : 2'b01);
      cyc(4); rise_cnt = 0; cyc(20);
      check("R4 no edge unless supply on", rise_cnt, 0);
      check("R4 clock held low", int'(card_clk), 0);
      pwr_state = 2'b11;
    end

    // R11: idle without power saving keeps running
    @(negedge clk); cmd_idle = 1'b1; dat_idle = 1'b1;
    cyc(5); rise_cnt = 0; cyc(40);
    check("R11 idle ignored with psave off", rise_cnt, 10);

    // R7: power saving stops after IDLE_CYC edges
    @(negedge clk); cmd_idle = 1'b0; psave_en = 1'b1;
    cyc(4);
    @(posedge clk); #2;
    while (card_rise !== 1'b0) begin @(posedge clk); #2; end
    @(negedge clk); cmd_idle = 1'b1; rise_cnt = 0;
    cyc(60);
    check("R7 edges before power-save gating", rise_cnt, IC);
    check("R7 clock gated low", int'(card_clk), 0);

    // R8: activity resumes on the next host edge
    @(negedge clk); dat_idle = 1'b0;
    @(posedge clk); #2;
    check("R8 clock high next host edge", int'(card_clk), 1);
    check("R8 strobe on resume", int'(card_rise), 1);
    @(negedge clk); cmd_idle = 1'b0; psave_en = 1'b0; div_ratio = 4'd5;

    // R10: switch to bypass during a high phase
    cyc(14);
    wait_rise();
    @(negedge clk); bypass = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2;
      check("R10 high phase finishes before switch", int'(card_clk), 1);
    end
    cyc(20); rise_cnt = 0; cyc(10);
    check("R3 bypass strobe every cycle", rise_cnt, 10);
    @(negedge clk); #2;
    check("R3 bypass low half", int'(card_clk), 0);
    @(posedge clk); #2;
    check("R3 bypass high half", int'(card_clk), 1);

    // R4 in bypass
    @(negedge clk); pwr_state = 2'b00;
    cyc(4); rise_cnt = 0; cyc(10);
    check("R4 bypass no edge when off", rise_cnt, 0);
    @(posedge clk); #2;
    check("R4 bypass held low", int'(card_clk), 0);

    // R10: back to divide, ratio 0
    @(negedge clk); bypass = 1'b0; pwr_state = 2'b11; div_ratio = 4'd0;
    cyc(20); rise_cnt = 0; cyc(20);
    check("R10 divide after switch back, N=0", rise_cnt, 10);
    check("R2 high length N=0", last_hi, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule